// File: doc/BRIEF.md
# Peripheral Privilege Access Filter

This block sits on the path from one bus master to a bank of up to 64 peripheral register slots. Each access carries a slot index, a privilege flag, a direction, an address and write data. A per-slot protection bit says whether that slot may be touched only by privileged code. When filtering is on and an unprivileged access hits a protected slot, the access is intercepted. No slot select is raised, a read returns zero, and the block raises a fault flag and records which slot was aimed at. All other accesses pass straight through to the addressed slot.

A separate configuration port holds the controls. These are the filter enable, two 32-bit protection words, the interrupt flags with set and clear strobes, an interrupt enable mask, and the captured fault slot ID. Every access on either port completes in the cycle it is presented, so the master never waits.

Top module: `periph_priv_filter`

## Requirements
- R1: An access with valid high, privilege low, filter enabled and the target slot's protection bit set raises no slot select and no peripheral write strobe.
- R2: An intercepted read returns all-zero data on the master read bus.
- R3: An intercepted access sets flag bit 0 at the next clock edge and loads its slot ID into the fault ID register (config address 7). Each later interception overwrites the ID.
- R4: Slots 0 to 31 are guarded by bit n of the word at config address 1. Slot n of 32 or above is guarded by bit n-32 of the word at config address 2.
- R5: With enable bit 0 of config address 0 cleared, every access is forwarded whatever the protection bits are, and no flag is set.
- R6: A forwarded access drives exactly one slot select, the one for its ID. Address, write data and direction pass through unchanged, read data comes from the peripheral bus, and ready equals valid in the same cycle.
- R7: The interrupt output equals the flag register (address 3) ANDed with the enable mask (address 6). Reading address 4 returns the same AND, and no read clears a flag.
- R8: A privileged write to address 4 ORs its data into the flags, and one to address 5 clears the flags whose data bits are set. A flag may be pending while its enable bit is 0. Address 3 is read-only.
- R9: When an interception and a software clear of flag 0 fall in the same cycle, flag 0 ends set.
- R10: After reset the filter is enabled, both protection words, the flags, the enable mask and the fault ID read zero, and the interrupt output is zero.
- R11: A configuration write with the privilege input low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_valid | input | 1 | Master access present |
| m_priv | input | 1 | Master access is privileged |
| m_write | input | 1 | Master access is a write |
| m_pid | input | PID_W | Target slot index |
| m_addr | input | AW | Register address inside the slot |
| m_wdata | input | DW | Master write data |
| m_rdata | output | DW | Read data back to the master |
| m_ready | output | 1 | Access complete this cycle |
| p_sel | output | NPERIPH | One-hot slot select |
| p_write | output | 1 | Write strobe to the selected slot |
| p_addr | output | AW | Address to the slots |
| p_wdata | output | DW | Write data to the slots |
| p_rdata | input | DW | Read data from the selected slot |
| cfg_valid | input | 1 | Configuration access present |
| cfg_priv | input | 1 | Configuration access is privileged |
| cfg_write | input | 1 | Configuration access is a write |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| irq | output | IRQ_W | Enabled and pending interrupts |

## Verification
The bench mixes unprivileged and privileged accesses to slots on both sides of the 31/32 word boundary, against protection words it has programmed. This separates word-selection errors from privilege-gating errors. Runs with the filter switched off show whether the enable really bypasses the protection bits. Unprivileged configuration writes show whether privilege is checked on that port too. Collisions of an interception with a software clear pin down set/clear priority. Repeated reads of the masked status address show that reads are side-effect free. A long seeded random run then cross-checks every output against a register-level model.

// File: rtl/ppf_pkg.sv
package ppf_pkg;
   localparam int ATTR_WORD = 32;
   localparam int FAULT_BIT = 0;

   typedef enum logic [2:0] {
      RA_CTRL    = 3'd0,
      RA_ATTR_LO = 3'd1,
      RA_ATTR_HI = 3'd2,
      RA_FLAGS   = 3'd3,
      RA_FSET    = 3'd4,
      RA_FCLR    = 3'd5,
      RA_IEN     = 3'd6,
      RA_FID     = 3'd7
   } ppf_reg_e;
endpackage

// File: rtl/ppf_gate.sv
module ppf_gate #(
   parameter int NPERIPH = 64,
   parameter int PID_W   = 6,
   parameter int AW      = 12,
   parameter int DW      = 32
) (
   input  logic               m_valid,
   input  logic               m_priv,
   input  logic               m_write,
   input  logic [PID_W-1:0]   m_pid,
   input  logic [AW-1:0]      m_addr,
   input  logic [DW-1:0]      m_wdata,
   output logic [DW-1:0]      m_rdata,
   output logic               m_ready,
   output logic [NPERIPH-1:0] p_sel,
   output logic               p_write,
   output logic [AW-1:0]      p_addr,
   output logic [DW-1:0]      p_wdata,
   input  logic [DW-1:0]      p_rdata,
   input  logic [NPERIPH-1:0] prot_vec,
   input  logic               filt_en,
   output logic               blk
);
   localparam int SLOTS = 1 << PID_W;
   localparam logic [PID_W:0] CNT = NPERIPH[PID_W:0];

   logic [SLOTS-1:0] prot_ext;
   logic             in_rng, fwd;

   for (genvar i = 0; i < SLOTS; i++) begin : g_ext
      if (i < NPERIPH) begin : g_real
         assign prot_ext[i] = prot_vec[i];
      end else begin : g_pad
         assign prot_ext[i] = 1'b0;
      end
   end

   assign in_rng = ({1'b0, m_pid} < CNT);
   assign blk    = m_valid & filt_en & ~m_priv & prot_ext[m_pid];
   assign fwd    = m_valid & ~blk & in_rng;

   for (genvar i = 0; i < NPERIPH; i++) begin : g_sel
      assign p_sel[i] = fwd & (m_pid == PID_W'(i));
   end

   assign p_write = fwd & m_write;
   assign p_addr  = m_addr;
   assign p_wdata = m_wdata;
   assign m_rdata = fwd ? p_rdata : '0;
   assign m_ready = m_valid;
endmodule

// File: rtl/ppf_regs.sv
module ppf_regs #(
   parameter int IRQ_W = 4,
   parameter int PID_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_valid,
   input  logic             cfg_priv,
   input  logic             cfg_write,
   input  logic [2:0]       cfg_addr,
   input  logic [31:0]      cfg_wdata,
   output logic [31:0]      cfg_rdata,
   input  logic [IRQ_W-1:0] flags,
   input  logic [IRQ_W-1:0] ien,
   input  logic [PID_W-1:0] fid,
   output logic             filt_en,
   output logic [31:0]      attr_lo,
   output logic [31:0]      attr_hi,
   output logic [IRQ_W-1:0] set_mask,
   output logic [IRQ_W-1:0] clr_mask,
   output logic             ien_we
);
   import ppf_pkg::*;

   logic     we;
   ppf_reg_e ra;

   assign we = cfg_valid & cfg_write & cfg_priv;
   assign ra = ppf_reg_e'(cfg_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_en <= 1'b1;
         attr_lo <= '0;
         attr_hi <= '0;
      end else if (we) begin
         if (ra == RA_CTRL)    filt_en <= cfg_wdata[0];
         if (ra == RA_ATTR_LO) attr_lo <= cfg_wdata;
         if (ra == RA_ATTR_HI) attr_hi <= cfg_wdata;
      end
   end

   assign set_mask = (we && ra == RA_FSET) ? cfg_wdata[IRQ_W-1:0] : '0;
   assign clr_mask = (we && ra == RA_FCLR) ? cfg_wdata[IRQ_W-1:0] : '0;
   assign ien_we   = we && ra == RA_IEN;

   always_comb begin
      cfg_rdata = '0;
      case (ra)
         RA_CTRL:    cfg_rdata = {31'b0, filt_en};
         RA_ATTR_LO: cfg_rdata = attr_lo;
         RA_ATTR_HI: cfg_rdata = attr_hi;
         RA_FLAGS:   cfg_rdata = 32'(flags);
         RA_FSET:    cfg_rdata = 32'(flags & ien);
         RA_IEN:     cfg_rdata = 32'(ien);
         RA_FID:     cfg_rdata = 32'(fid);
         default:    cfg_rdata = '0;
      endcase
   end

   AST_UNPRIV_CFG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && cfg_write && !cfg_priv) |=>
      ($stable(filt_en) && $stable(attr_lo) && $stable(attr_hi))); // R11
endmodule

// File: rtl/ppf_irq.sv
module ppf_irq #(
   parameter int IRQ_W = 4,
   parameter int PID_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_W-1:0] set_mask,
   input  logic [IRQ_W-1:0] clr_mask,
   input  logic             ien_we,
   input  logic [IRQ_W-1:0] ien_wdata,
   input  logic             hw_fault,
   input  logic [PID_W-1:0] hw_pid,
   output logic [IRQ_W-1:0] flags,
   output logic [IRQ_W-1:0] ien,
   output logic [PID_W-1:0] fid,
   output logic [IRQ_W-1:0] irq
);
   import ppf_pkg::*;

   logic [IRQ_W-1:0] hw_mask;

   assign hw_mask = hw_fault ? IRQ_W'(1 << FAULT_BIT) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         ien   <= '0;
         fid   <= '0;
      end else begin
         flags <= (flags & ~clr_mask) | set_mask | hw_mask;
         if (ien_we)   ien <= ien_wdata;
         if (hw_fault) fid <= hw_pid;
      end
   end

   assign irq = flags & ien;

   AST_HW_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      hw_fault |=> flags[FAULT_BIT]); // R9
   AST_FID_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      hw_fault |=> (fid == $past(hw_pid))); // R3
endmodule

// File: rtl/periph_priv_filter.sv
module periph_priv_filter #(
   parameter int NPERIPH = 64,
   parameter int AW      = 12,
   parameter int DW      = 32,
   parameter int IRQ_W   = 4,
   localparam int PID_W  = (NPERIPH > 1) ? $clog2(NPERIPH) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               m_valid,
   input  logic               m_priv,
   input  logic               m_write,
   input  logic [PID_W-1:0]   m_pid,
   input  logic [AW-1:0]      m_addr,
   input  logic [DW-1:0]      m_wdata,
   output logic [DW-1:0]      m_rdata,
   output logic               m_ready,
   output logic [NPERIPH-1:0] p_sel,
   output logic               p_write,
   output logic [AW-1:0]      p_addr,
   output logic [DW-1:0]      p_wdata,
   input  logic [DW-1:0]      p_rdata,
   input  logic               cfg_valid,
   input  logic               cfg_priv,
   input  logic               cfg_write,
   input  logic [2:0]         cfg_addr,
   input  logic [31:0]        cfg_wdata,
   output logic [31:0]        cfg_rdata,
   output logic [IRQ_W-1:0]   irq
);
   import ppf_pkg::*;

   if (NPERIPH < 1 || NPERIPH > 2 * ATTR_WORD) begin : g_bad_n
      $error("NPERIPH must lie in 1..64");
   end
   if (IRQ_W < 1 || IRQ_W > 32) begin : g_bad_irq
      $error("IRQ_W must lie in 1..32");
   end

   logic               filt_en, blk, ien_we;
   logic [31:0]        attr_lo, attr_hi;
   logic [NPERIPH-1:0] prot_vec;
   logic [IRQ_W-1:0]   flags, ien, set_mask, clr_mask;
   logic [PID_W-1:0]   fid;

   for (genvar i = 0; i < NPERIPH; i++) begin : g_prot
      if (i < ATTR_WORD) begin : g_lo
         assign prot_vec[i] = attr_lo[i];
      end else begin : g_hi
         assign prot_vec[i] = attr_hi[i-ATTR_WORD];
      end
   end

   ppf_gate #(.NPERIPH(NPERIPH), .PID_W(PID_W), .AW(AW), .DW(DW)) u_gate (
      .m_valid(m_valid), .m_priv(m_priv), .m_write(m_write), .m_pid(m_pid),
      .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready),
      .p_sel(p_sel), .p_write(p_write), .p_addr(p_addr), .p_wdata(p_wdata),
      .p_rdata(p_rdata), .prot_vec(prot_vec), .filt_en(filt_en), .blk(blk));

   ppf_regs #(.IRQ_W(IRQ_W), .PID_W(PID_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_priv(cfg_priv),
      .cfg_write(cfg_write), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .flags(flags), .ien(ien), .fid(fid),
      .filt_en(filt_en), .attr_lo(attr_lo), .attr_hi(attr_hi),
      .set_mask(set_mask), .clr_mask(clr_mask), .ien_we(ien_we));

   ppf_irq #(.IRQ_W(IRQ_W), .PID_W(PID_W)) u_irq (
      .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask),
      .ien_we(ien_we), .ien_wdata(cfg_wdata[IRQ_W-1:0]), .hw_fault(blk),
      .hw_pid(m_pid), .flags(flags), .ien(ien), .fid(fid), .irq(irq));

   AST_BLOCK_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_priv && filt_en && prot_vec[m_pid]) |-> (p_sel == '0 && !p_write)); // R1
   AST_BLOCK_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_write && !m_priv && filt_en && prot_vec[m_pid]) |-> (m_rdata == '0)); // R2
   AST_BLOCK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_priv && filt_en && prot_vec[m_pid]) |=> flags[FAULT_BIT]); // R3
   AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !filt_en) |-> ($onehot(p_sel) && p_sel[m_pid])); // R5
   AST_READ_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cfg_valid && cfg_write) && !(m_valid && !m_priv && filt_en && prot_vec[m_pid]))
      |=> $stable(flags)); // R7
endmodule

// File: tb/periph_priv_filter_tb_top.sv
module periph_priv_filter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_valid = 0, m_priv = 0, m_write = 0;
   logic [5:0]  m_pid = 0;
   logic [11:0] m_addr = 0;
   logic [31:0] m_wdata = 0, m_rdata, p_wdata, p_rdata = 0;
   logic        m_ready, p_write;
   logic [63:0] p_sel;
   logic [11:0] p_addr;
   logic        cfg_valid = 0, cfg_priv = 0, cfg_write = 0;
   logic [2:0]  cfg_addr = 0;
   logic [31:0] cfg_wdata = 0, cfg_rdata;
   logic [3:0]  irq;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // bench register model
   logic        md_en = 1;
   logic [31:0] md_lo = 0, md_hi = 0;
   logic [3:0]  md_flag = 0, md_ien = 0;
   logic [5:0]  md_fid = 0;

   always #10 clk = ~clk;

   periph_priv_filter dut_i (
      .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_priv(m_priv),
      .m_write(m_write), .m_pid(m_pid), .m_addr(m_addr), .m_wdata(m_wdata),
      .m_rdata(m_rdata), .m_ready(m_ready), .p_sel(p_sel), .p_write(p_write),
      .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
      .cfg_valid(cfg_valid), .cfg_priv(cfg_priv), .cfg_write(cfg_write),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .irq(irq));

   function automatic logic prot_of(input logic [5:0] pid);
      return (pid < 32) ? md_lo[pid[4:0]] : md_hi[pid[4:0]];
   endfunction

   function automatic logic [31:0] rd_of(input logic [2:0] a);
      case (a)
         3'd0: return {31'b0, md_en};
         3'd1: return md_lo;
         3'd2: return md_hi;
         3'd3: return {28'b0, md_flag};
         3'd4: return {28'b0, md_flag & md_ien};
         3'd6: return {28'b0, md_ien};
         3'd7: return {26'b0, md_fid};
         default: return 32'b0;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] a);
      case (a)
         3'd0: return "R5";
         3'd1, 3'd2: return "R4";
         3'd3, 3'd5: return "R8";
         3'd7: return "R3";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic mv, input logic [5:0] pid, input logic mp, input logic mw,
                      input logic cv, input logic cp, input logic cw, input logic [2:0] ca,
                      input logic [31:0] cd, input string tag);
      logic eb;
      m_valid = mv; m_pid = pid; m_priv = mp; m_write = mw;
      m_addr = 12'($urandom); m_wdata = $urandom; p_rdata = $urandom;
      cfg_valid = cv; cfg_priv = cp; cfg_write = cw; cfg_addr = ca; cfg_wdata = cd;
      eb = mv && md_en && prot_of(pid) && !mp;
      #5;
      if (mv) begin
         chk(m_ready === 1'b1, "R6", 64'(m_ready), 64'd1);
         if (eb) begin
            chk(p_sel === 64'd0 && p_write === 1'b0, "R1", p_sel, 64'd0);
            if (!mw) chk(m_rdata === 32'd0, "R2", 64'(m_rdata), 64'd0);
         end else begin
            chk(p_sel === (64'd1 << pid), md_en ? "R6" : "R5", p_sel, 64'd1 << pid);
            chk(p_write === mw && p_addr === m_addr && p_wdata === m_wdata, "R6",
                64'(p_write), 64'(mw));
            if (!mw) chk(m_rdata === p_rdata, "R6", 64'(m_rdata), 64'(p_rdata));
         end
      end else begin
         chk(p_sel === 64'd0 && m_ready === 1'b0, "R6", p_sel, 64'd0);
      end
      chk(irq === (md_flag & md_ien), "R7", 64'(irq), 64'(md_flag & md_ien));
      if (cv && !cw) chk(cfg_rdata === rd_of(ca), tag, 64'(cfg_rdata), 64'(rd_of(ca)));
      @(posedge clk);
      if (cv && cw && cp) begin
         case (ca)
            3'd0: md_en = cd[0];
            3'd1: md_lo = cd;
            3'd2: md_hi = cd;
            3'd4: md_flag = md_flag | cd[3:0];
            3'd5: md_flag = md_flag & ~cd[3:0];
            3'd6: md_ien = cd[3:0];
            default: ;
         endcase
      end
      if (eb) begin
         md_flag[0] = 1'b1;
         md_fid = pid;
      end
      @(negedge clk);
      m_valid = 0; cfg_valid = 0;
   endtask

   task automatic rd(input logic [2:0] a, input string tag);
      cyc(0, 0, 0, 0, 1, 1, 0, a, 0, tag);
   endtask

   task automatic wr(input logic p, input logic [2:0] a, input logic [31:0] d);
      cyc(0, 0, 0, 0, 1, p, 1, a, d, "R11");
   endtask

   task automatic acc(input logic [5:0] pid, input logic p, input logic w);
      cyc(1, pid, p, w, 0, 0, 0, 0, 0, "R6");
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      for (int a = 0; a < 8; a++) rd(3'(a), "R10");
      chk(irq === 4'd0, "R10", 64'(irq), 64'd0);
      // R4 word mapping across the 31/32 boundary
      wr(1, 3'd1, 32'h1 << 5);
      wr(1, 3'd2, 32'h1 << 8);
      rd(3'd1, "R4"); rd(3'd2, "R4");
      acc(6'd40, 0, 0);            // blocked read, R1 R2
      rd(3'd3, "R3"); rd(3'd7, "R3");
      acc(6'd5, 0, 1);             // blocked write overwrites ID
      rd(3'd7, "R3");
      acc(6'd40, 1, 0);            // privileged passes
      acc(6'd41, 0, 0);            // neighbour unguarded, R4
      acc(6'd8, 0, 1);             // bit 8 of low word clear, R4
      acc(6'd37, 0, 0);
      // R11 unprivileged config writes
      wr(0, 3'd1, 32'hFFFF_FFFF);
      rd(3'd1, "R11");
      wr(0, 3'd0, 32'd0);
      rd(3'd0, "R11");
      wr(0, 3'd5, 32'hF);
      rd(3'd3, "R11");
      // R9 clear collides with an interception
      cyc(1, 6'd5, 0, 0, 1, 1, 1, 3'd5, 32'h1, "R9");
      rd(3'd3, "R9");
      // R8 software set while masked, then unmask
      wr(1, 3'd5, 32'hF);
      rd(3'd3, "R8");
      wr(1, 3'd4, 32'h4);
      rd(3'd3, "R8");
      wr(1, 3'd3, 32'hF);          // read-only address
      rd(3'd3, "R8");
      wr(1, 3'd6, 32'h4);
      rd(3'd4, "R7"); rd(3'd4, "R7"); rd(3'd3, "R7");
      // R5 filter off
      wr(1, 3'd0, 32'd0);
      acc(6'd40, 0, 0); acc(6'd5, 0, 1);
      rd(3'd3, "R5");
      wr(1, 3'd0, 32'd1);
      acc(6'd40, 0, 1);
      // random mix
      for (int k = 0; k < 4000; k++) begin
         logic [2:0] ca;
         ca = 3'($urandom);
         cyc($urandom_range(0, 3) != 0, 6'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0, ca,
             (ca == 3'd0) ? {31'b0, $urandom_range(0, 5) != 0} : $urandom, tag_of(ca));
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule